// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a programmable up-counter that divides the system clock into a slower tick and counts those ticks. When the count reaches a programmable reference value, it returns to zero and latches a reference event. If the event is enabled as an interrupt, an interrupt request is raised until software clears the event. A firmware-visible register port is used to program the block. A single register select addresses four registers: mode, reference, live count and event. Writes are single-cycle strobes, and reads are combinational.

The base rate is the system clock, nominally 66 MHz. The base rate can be used directly or after a fixed divide-by-16. After that, an 8-bit prescaler divides it by a value from 1 to 256. Only restart-at-reference counting is supported. A mode that requests an unsupported clock source, or that leaves restart mode off, is reported on an error output, and the counter stays frozen.

Top module: `refTimer`

## Requirements
- R1: After reset, the mode register (select 0) reads 0x0000, the reference register (select 1) reads 0xFFFF, and the count (select 2) and event (select 3) registers read 0. `irqOut` and `modeErr` are low.
- R2: Mode field bits 2:1 set to 01 selects the system clock. The count advances once every P+1 clocks, where P is mode bits 15:8.
- R3: Mode field bits 2:1 set to 10 selects the system clock divided by 16. The count advances once every 16*(P+1) clocks.
- R4: The count runs 0,1,..,R, where R is the reference value. On the tick after it reaches R it returns to 0 and sets event bit 0, so a full cycle is R+1 ticks.
- R5: `irqOut` is high exactly when mode bit 4 (interrupt enable) is 1 and event bit 0 is 1.
- R6: Writing the event register with bit 0 set clears the event, and `irqOut` is low from the next cycle. Writing the event register with bit 0 clear leaves the event unchanged.
- R7: While mode bit 0 is 0, the count does not change.
- R8: Writing mode bit 0 as 0 when it was 1 returns mode, reference, count and event to their R1 values, whatever the other written bits are.
- R9: `modeErr` is high when mode bit 0 is 1 and either bits 2:1 are 00 or 11, or restart bit 3 is 0. While `modeErr` is high the count does not change.
- R10: A write to the count register loads the written value, and counting continues upward from it.
- R11: A write to the mode register (other than the R8 case) or to the reference register sets the count to 0 and restarts the prescale sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 mode, 1 reference, 2 count, 3 event |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `regAddr` |
| irqOut | output | 1 | Interrupt request |
| modeErr | output | 1 | Unsupported mode programmed while enabled |

## Verification
Two kinds of internal fault show up at the ports in different ways. A prescaler phase error or a wrong source divide shows up in the live count at the first tick, which is at most 16*(P+1) clocks after a restart. A compare or wrap fault shows up as a count that passes R, or as an event that appears one tick early or late, within R+1 ticks. Faults in event-latch or clear behaviour are visible on `irqOut` and in the event register the cycle after the write. The sweep covers both clock sources, several prescale values and several reference values. It tracks the expected count and event cycle by cycle from a closed-form function of elapsed clocks.

// File: rtl/refTimerPkg.sv
package refTimerPkg;
  localparam int MODE_EN      = 0;
  localparam int MODE_SRC_LO  = 1;
  localparam int MODE_SRC_HI  = 2;
  localparam int MODE_RESTART = 3;
  localparam int MODE_IRQEN   = 4;
  localparam int MODE_PRE_LO  = 8;

  typedef enum logic [1:0] {
    REG_MODE  = 2'd0,
    REG_REF   = 2'd1,
    REG_COUNT = 2'd2,
    REG_EVENT = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    SRC_BAD0  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SYS16 = 2'd2,
    SRC_BAD3  = 2'd3
  } clkSrc_e;

  typedef struct packed {
    logic softReset;
    logic restart;
    logic wrRef;
    logic wrCount;
    logic clrEvt;
    logic tick;
  } ctlStb_t;
endpackage

// File: rtl/refTimerCtrl.sv
module refTimerCtrl
  import refTimerPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] modeReg,
  output ctlStb_t           stb,
  output logic              modeErr
);
  localparam int PRE_W  = DATA_W - MODE_PRE_LO;
  localparam int BASE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [BASE_W-1:0] BASE_LAST = BASE_W'(SLOW_DIV - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [BASE_W-1:0] baseCnt;
  logic [PRE_W-1:0]  preDiv;
  clkSrc_e           srcSel;
  logic              wrMode;
  logic              running;
  logic              baseTick;
  logic              preWrap;

  assign preDiv  = modeReg[DATA_W-1:MODE_PRE_LO];
  assign srcSel  = clkSrc_e'(modeReg[MODE_SRC_HI:MODE_SRC_LO]);
  assign wrMode  = wrEn && (regAddr == REG_MODE);

  assign modeErr = modeReg[MODE_EN] &&
                   ((srcSel == SRC_BAD0) || (srcSel == SRC_BAD3) || !modeReg[MODE_RESTART]);
  assign running = modeReg[MODE_EN] && !modeErr;

  assign baseTick = (srcSel == SRC_SYS) || (baseCnt == BASE_LAST);
  assign preWrap  = (preCnt == preDiv);

  always_comb begin
    stb           = '0;
    stb.softReset = wrMode && modeReg[MODE_EN] && !wrData[MODE_EN];
    stb.wrRef     = wrEn && (regAddr == REG_REF);
    stb.wrCount   = wrEn && (regAddr == REG_COUNT);
    stb.clrEvt    = wrEn && (regAddr == REG_EVENT) && wrData[0];
    stb.restart   = wrMode || stb.wrRef;
    stb.tick      = running && baseTick && preWrap && !stb.restart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (stb.softReset) begin
      modeReg <= '0;
    end else if (wrMode) begin
      modeReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
      preCnt  <= '0;
    end else if (stb.restart) begin
      baseCnt <= '0;
      preCnt  <= '0;
    end else if (running) begin
      baseCnt <= (baseCnt == BASE_LAST) ? '0 : baseCnt + 1'b1;
      if (baseTick) begin
        preCnt <= preWrap ? '0 : preCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refTimerDatapath.sv
module refTimerDatapath
  import refTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStb_t          stb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] refReg,
  output logic [CNT_W-1:0] countReg,
  output logic             evtFlag
);
  logic atRef;
  logic refHit;

  assign atRef  = (countReg == refReg);
  assign refHit = stb.tick && !stb.wrCount && atRef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refReg <= '1;
    end else if (stb.softReset) begin
      refReg <= '1;
    end else if (stb.wrRef) begin
      refReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= '0;
    end else if (stb.softReset) begin
      countReg <= '0;
    end else if (stb.wrCount) begin
      countReg <= wrData;
    end else if (stb.restart) begin
      countReg <= '0;
    end else if (stb.tick) begin
      countReg <= atRef ? '0 : countReg + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtFlag <= 1'b0;
    end else if (stb.softReset) begin
      evtFlag <= 1'b0;
    end else if (refHit) begin
      evtFlag <= 1'b1;
    end else if (stb.clrEvt) begin
      evtFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/refTimer.sv
module refTimer
  import refTimerPkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int SLOW_DIV = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              modeErr
);
  logic [DATA_W-1:0] modeReg;
  logic [DATA_W-1:0] refReg;
  logic [DATA_W-1:0] countReg;
  logic              evtFlag;
  ctlStb_t           ctlStb;

  refTimerCtrl #(.DATA_W(DATA_W), .SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .modeReg(modeReg), .stb(ctlStb), .modeErr(modeErr)
  );

  refTimerDatapath #(.CNT_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .wrData(wrData),
    .refReg(refReg), .countReg(countReg), .evtFlag(evtFlag)
  );

  assign irqOut = modeReg[MODE_IRQEN] && evtFlag;

  always_comb begin
    unique case (regAddr)
      REG_MODE:  rdData = modeReg;
      REG_REF:   rdData = refReg;
      REG_COUNT: rdData = countReg;
      default:   rdData = {{(DATA_W-1){1'b0}}, evtFlag};
    endcase
  end
endmodule

// File: rtl/refTimerChecker.sv
module refTimerChecker
  import refTimerPkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              irqOut,
  input logic              modeErr,
  input logic [DATA_W-1:0] modeReg,
  input logic [DATA_W-1:0] refReg,
  input logic [DATA_W-1:0] countReg,
  input ctlStb_t           ctlStb
);
  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStb.tick && !wrEn) |=> (countReg == '0 || countReg == $past(countReg) + 1'b1)); // R4

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == REG_EVENT && wrData[0] && !ctlStb.tick) |=> !irqOut); // R6

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!modeReg[MODE_EN] && !wrEn) |=> $stable(countReg)); // R7

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == REG_MODE && modeReg[MODE_EN] && !wrData[MODE_EN])
      |=> (modeReg == '0 && refReg == '1 && countReg == '0 && !irqOut)); // R8

  AST_ERR_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    (modeErr && !wrEn) |=> $stable(countReg)); // R9

  AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regAddr == REG_COUNT) |=> countReg == $past(wrData)); // R10

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> modeReg[MODE_IRQEN]); // R5
endmodule

bind refTimer refTimerChecker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
  .irqOut(irqOut), .modeErr(modeErr), .modeReg(modeReg), .refReg(refReg),
  .countReg(countReg), .ctlStb(ctlStb)
);

// File: tb/test_refTimer.sv
module test_refTimer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irqOut;
  logic        modeErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  refTimer i_refTimer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .irqOut(irqOut), .modeErr(modeErr)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    regAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(2'd0, v); check("R1 mode", v, 0);
    rd(2'd1, v); check("R1 ref", v, 16'hFFFF);
    rd(2'd2, v); check("R1 count", v, 0);
    rd(2'd3, v); check("R1 event", v, 0);
    check("R1 irq", int'(irqOut), 0);
    check("R1 err", int'(modeErr), 0);

    // R9 unsupported modes freeze the counter
    wr(2'd0, 16'h0001); check("R9 src0", int'(modeErr), 1);
    idle(5); rd(2'd2, v); check("R9 frozen src0", v, 0);
    wr(2'd0, 16'h000F); check("R9 src3", int'(modeErr), 1);
    idle(5); rd(2'd2, v); check("R9 frozen src3", v, 0);
    wr(2'd0, 16'h0003); check("R9 no restart", int'(modeErr), 1);
    idle(5); rd(2'd2, v); check("R9 frozen norestart", v, 0);
    wr(2'd0, 16'h000B); check("R9 valid", int'(modeErr), 0);
    idle(3); rd(2'd2, v); check("R9 runs when valid", v, 3);

    // R8 soft reset on enable falling
    wr(2'd1, 16'd9);
    wr(2'd0, 16'hFF1A);
    rd(2'd0, v); check("R8 mode", v, 0);
    rd(2'd1, v); check("R8 ref", v, 16'hFFFF);
    rd(2'd2, v); check("R8 count", v, 0);
    rd(2'd3, v); check("R8 event", v, 0);

    // R7 disabled counter holds a loaded value
    wr(2'd0, 16'h000A);
    wr(2'd2, 16'd7);
    idle(10); rd(2'd2, v); check("R7 stopped", v, 7);
    check("R7 no err while disabled", int'(modeErr), 0);

    // R10 count load then continue, R11 reference write restarts
    wr(2'd0, 16'h000B);
    wr(2'd2, 16'd40);
    rd(2'd2, v); check("R10 loaded", v, 40);
    idle(5); rd(2'd2, v); check("R10 continues", v, 45);
    wr(2'd1, 16'd100);
    rd(2'd2, v); check("R11 ref write restart", v, 0);
    idle(3); rd(2'd2, v); check("R11 counting after restart", v, 3);

    // R2 R3 R4 R5 R11 sweep of source, prescale, reference
    for (int s = 1; s <= 2; s++) begin
      for (int pi = 0; pi < 4; pi++) begin
        for (int ri = 0; ri < 4; ri++) begin
          int p, r, ori, lim;
          p   = (pi == 3) ? 5 : pi;
          r   = (ri == 3) ? 6 : ((ri == 2) ? 3 : ri);
          ori = ri & 1;
          wr(2'd0, 16'h0000);
          wr(2'd1, 16'(r));
          wr(2'd0, 16'((p << 8) | (ori << 4) | 8 | (s << 1) | 1));
          lim = ((s == 2) ? 16 : 1) * (p + 1) * (r + 2) + 3;
          for (int n = 0; n <= lim; n++) begin
            int base, t, ec, ee;
            base = (s == 2) ? n / 16 : n;
            t    = base / (p + 1);
            ec   = t % (r + 1);
            ee   = (t >= r + 1) ? 1 : 0;
            rd(2'd2, v);
            check((s == 2) ? "R3 count" : "R2 count", v, ec);
            rd(2'd3, v); check("R4 event", v, ee);
            check("R5 irq", int'(irqOut), ori & ee);
            @(negedge clk);
          end
        end
      end
    end

    // R6 event clear behaviour (event is set, irq enabled, src1 P0)
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h001B);
    idle(4);
    rd(2'd3, v); check("R6 event set", v, 1);
    wr(2'd1, 16'hFFFF);
    wr(2'd3, 16'h0000);
    rd(2'd3, v); check("R6 write0 keeps", v, 1);
    check("R6 irq kept", int'(irqOut), 1);
    wr(2'd3, 16'h0001);
    check("R6 irq drops", int'(irqOut), 0);
    rd(2'd3, v); check("R6 event cleared", v, 0);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule